// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address sequence for a four-beat memory burst. A burst begins when either of two active-low address strobes is seen at a rising clock edge. One strobe serves a processor and the other a cache controller. On that edge the block captures a full word address. From then on, each clock edge at which the active-low advance input is low moves the burst one beat further. Only the low two bits of the address take part in the stepping. The upper bits stay fixed until the next strobe.

A static order-select input chooses the stepping pattern. Low selects a linear count that wraps within the group of four. High selects an interleaved pattern, in which each beat's low bits are the starting offset XOR the beat number. The current address and a burst-active flag are driven combinationally from registers, so they change in the cycle after the edge that caused the change. The block can sit in front of any synchronous memory array that expects such a sequence.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state. After that edge `addr_out` is 0 and `burst_active` is 0.
- R2: If `ads_proc_n` or `ads_ctrl_n` (or both) is low at a rising edge, `addr_out` equals the sampled `addr_in` after that edge, and `burst_active` is 1.
- R3: With `order_sel` = 0, each advance step sets the low two bits of `addr_out` to the start offset plus the beat count, modulo 4. Example: 2,3,0,1.
- R4: With `order_sel` = 1, the low two bits of `addr_out` equal the start offset XOR the beat count. Example for start offset 1: 1,0,3,2.
- R5: The upper 14 bits of `addr_out` do not change on any edge without a strobe, advance or not.
- R6: After four advance steps the low bits are back at the start offset, and further steps keep cycling.
- R7: When a strobe and `adv_n` are both low at the same edge, the new address is loaded and the beat count restarts at 0.
- R8: When both strobes and `adv_n` are high at an edge, `addr_out` and `burst_active` keep their values.
- R9: An advance while `burst_active` is 0 (no strobe) has no effect: `addr_out` stays 0 and `burst_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| ads_proc_n | input | 1 | Processor-side burst start strobe, active low |
| ads_ctrl_n | input | 1 | Controller-side burst start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | 16 | Word address captured on a strobe |
| addr_out | output | 16 | Current burst address |
| burst_active | output | 1 | High once a burst has been started |

## Verification
The bench builds the block with its default values: a 16-bit address and a 2-bit burst counter. With these values a full wrap of the group of four takes only four advance steps, so every start offset in both orderings and repeated wraps are reached within a few dozen cycles. The random phase mixes both strobes, simultaneous strobe and advance, and mode flips mid-burst. These are compared each cycle against a behavioural model.

// File: rtl/burst_pkg.sv
// Shared types for the burst address generator.
// Assumes: a single command per clock edge, chosen by the decoder.
package burst_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STEP = 2'd2
    } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
// Turns the two start strobes and the advance input into one command.
// Assumes: strobes and advance are active low; a start always beats an advance,
// and an advance only counts once a burst has been started.
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic       ads_proc_n,
    input  logic       ads_ctrl_n,
    input  logic       adv_n,
    input  logic       burst_active,
    output burst_cmd_e cmd
);
    // Priority pick: load, then step, else hold.
    always_comb begin
        if (!ads_proc_n || !ads_ctrl_n)
            cmd = CMD_LOAD;
        else if (!adv_n && burst_active)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_offset_map.sv
// Maps start offset and beat count to the low address bits.
// Assumes: order_sel is static in normal use; linear adds, interleaved XORs.
module burst_offset_map #(
    parameter int OFS_W = 2
) (
    input  logic             order_sel,
    input  logic [OFS_W-1:0] start_ofs,
    input  logic [OFS_W-1:0] beat,
    output logic [OFS_W-1:0] ofs
);
    // Select the ordering pattern.
    always_comb begin
        if (order_sel)
            ofs = start_ofs ^ beat;
        else
            ofs = OFS_W'(start_ofs + beat);
    end
endmodule

// File: rtl/burst_offset_seq.sv
// Holds the start offset and beat counter; produces the current low bits.
// Assumes: cmd comes from burst_cmd_decode; the counter wraps naturally at 2**OFS_W.
module burst_offset_seq
    import burst_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  burst_cmd_e       cmd,
    input  logic             order_sel,
    input  logic [OFS_W-1:0] load_ofs,
    output logic [OFS_W-1:0] ofs
);
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] beat_q;

    // Capture start offset on load, count beats on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else begin
            case (cmd)
                CMD_LOAD: begin
                    start_q <= load_ofs;
                    beat_q  <= '0;
                end
                CMD_STEP: beat_q <= OFS_W'(beat_q + 1'b1);
                default:  ;
            endcase
        end
    end

    burst_offset_map #(.OFS_W(OFS_W)) u_map (
        .order_sel (order_sel),
        .start_ofs (start_q),
        .beat      (beat_q),
        .ofs       (ofs)
    );

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP && !order_sel) |=>
            (!$stable(order_sel) || ofs == OFS_W'($past(ofs) + 1'b1)));

    // R7
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (ofs == $past(load_ofs)));
endmodule

// File: rtl/burst_addr_gen.sv
// Burst address generator: captures a word address on either start strobe and
// steps its low OFS_W bits in linear or interleaved order on each advance.
// Assumes: synchronous active-low reset; outputs follow registers one edge later.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_proc_n,
    input  logic              ads_ctrl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              burst_active
);
    localparam int HI_W = ADDR_W - OFS_W;

    burst_cmd_e       cmd;
    logic [HI_W-1:0]  base_hi_q;
    logic [OFS_W-1:0] ofs;

    burst_cmd_decode u_dec (
        .ads_proc_n   (ads_proc_n),
        .ads_ctrl_n   (ads_ctrl_n),
        .adv_n        (adv_n),
        .burst_active (burst_active),
        .cmd          (cmd)
    );

    burst_offset_seq #(.OFS_W(OFS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .order_sel (order_sel),
        .load_ofs  (addr_in[OFS_W-1:0]),
        .ofs       (ofs)
    );

    // Capture upper address bits and mark the burst live on a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi_q    <= '0;
            burst_active <= 1'b0;
        end else if (cmd == CMD_LOAD) begin
            base_hi_q    <= addr_in[ADDR_W-1:OFS_W];
            burst_active <= 1'b1;
        end
    end

    assign addr_out = {base_hi_q, ofs};

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_proc_n || !ads_ctrl_n) |=> (addr_out == $past(addr_in) && burst_active));

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_proc_n && ads_ctrl_n) |=> $stable(addr_out[ADDR_W-1:OFS_W]));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads_proc_n && ads_ctrl_n && adv_n) |=>
            ($stable(burst_active) && (!$stable(order_sel) || $stable(addr_out))));

    // R9
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && ads_proc_n && ads_ctrl_n) |=>
            (!burst_active && addr_out == '0));
endmodule

// File: tb/sim_burst_addr_gen.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module sim_burst_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_proc_n = 1'b1;
    logic        ads_ctrl_n = 1'b1;
    logic        adv_n = 1'b1;
    logic        order_sel = 1'b0;
    logic [15:0] addr_in = '0;
    logic [15:0] addr_out;
    logic        burst_active;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int    m_hi = 0, m_start = 0, m_beat = 0, m_act = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    burst_addr_gen u0 (
        .clk, .rst_n, .ads_proc_n, .ads_ctrl_n, .adv_n,
        .order_sel, .addr_in, .addr_out, .burst_active
    );

    // Reference model: updates on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_start = 0; m_beat = 0; m_act = 0; m_tag = "R1";
        end else if (!ads_proc_n || !ads_ctrl_n) begin
            m_hi = addr_in >> 2; m_start = addr_in & 3; m_beat = 0; m_act = 1;
            m_tag = adv_n ? "R2" : "R7";
        end else if (!adv_n && m_act != 0) begin
            m_beat = (m_beat + 1) % 4;
            m_tag = (m_beat == 0) ? "R6" : (order_sel ? "R4" : "R3");
        end else if (!adv_n) begin
            m_tag = "R9";
        end else begin
            m_tag = "R8";
        end
    end

    function automatic int exp_addr();
        int o;
        o = order_sel ? (m_start ^ m_beat) : ((m_start + m_beat) % 4);
        return (m_hi << 2) | o;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the settled outputs, then drive the next cycle's inputs.
    task automatic cyc(bit p, bit c, bit a, bit m, logic [15:0] ad);
        @(negedge clk);
        check(m_tag, int'(addr_out), exp_addr());
        check(m_tag, int'(burst_active), m_act);
        if (m_tag != "R2" && m_tag != "R7" && m_tag != "R1")
            check("R5", int'(addr_out[15:2]), m_hi);
        ads_proc_n = p; ads_ctrl_n = c; adv_n = a; order_sel = m; addr_in = ad;
    endtask

    initial begin
        cyc(1, 1, 1, 0, 16'h0000);              // R1 reset held
        cyc(1, 1, 1, 0, 16'h0000);
        rst_n = 1'b1;
        cyc(1, 1, 0, 0, 16'h5555);              // R9 advance while idle
        cyc(1, 1, 0, 1, 16'h7777);
        cyc(0, 1, 1, 0, 16'h1232);              // R2 processor start, linear
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 16'hFFFF);   // R3, R6
        cyc(1, 1, 1, 0, 16'h0000);              // R8 hold
        cyc(1, 0, 1, 1, 16'hABCD);              // R2 controller start, interleaved
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 1, 16'h0000);   // R4, R6
        cyc(0, 0, 0, 1, 16'h4563);              // R7 start beats advance
        cyc(1, 1, 0, 1, 16'h0000);
        cyc(1, 0, 0, 0, 16'h0F02);              // R7 with linear order
        cyc(1, 1, 1, 0, 16'h0000);
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom_range(0, 15);
            cyc(r != 0, r != 1, $urandom_range(0, 2) == 0 ? 1'b1 : 1'b0,
                (i / 40) % 2 == 1 ? 1'b1 : ($urandom_range(0, 19) == 0),
                16'($urandom));
        end
        rst_n = 1'b0;
        cyc(1, 1, 1, 0, 16'h0000);
        cyc(1, 1, 1, 0, 16'h0000);              // R1 reset after activity
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule